// File: doc/BRIEF.md
# Nibble-Decomposed Unsigned Multiplier

This block is a purely combinational unsigned multiplier for two 8-bit operands that returns the full 16-bit product. It does not use one flat array for the whole product. Instead, it cuts each operand into a low half and a high half of four bits. Four small array multipliers form the four cross products: low×low, high×low, low×high and high×high. Each small multiplier is a square grid of cells, and each cell ANDs one bit of each operand and feeds the result into a full adder.

The four 8-bit cross products are then summed in 4-bit columns. The lowest column needs no adder. Each of the two middle columns adds three nibbles. It does this in two steps: a rank of full adders first reduces the three nibbles to a sum vector and a carry vector, and a short ripple adder then adds the sum vector to the carry vector moved up one bit. The top column adds one nibble plus whatever arrives from below. A middle column can overflow by as much as two, so its carry leaves as a two-wire code that stands for 0, 1 or 2.

A host datapath drives both operands and reads the product once the logic has settled. There is no clock and no state.

Top module: `decompMul8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prodOut` equals `opA × opB` exactly, as a 16-bit value.
- R2: `prodOut[3:0]` always equals the low nibble of `opA[3:0] × opB[3:0]`.
- R3: Each 4×4 sub-multiplier returns the exact 8-bit product of its two nibble inputs.
- R4: The carry from one middle column to the next is 0, 1 or 2, and never 3. It travels as a two-wire thermometer code: (0,0) means 0, (1,0) means 1 and (1,1) means 2. When operand 0x7F is squared, the column for bits 7:4 produces a carry of 2, and the product is still correct (0x3F01).
- R5: Each column adder returns the exact sum of its three nibble operands and its two carry-in wires.
- R6: A zero in either operand gives a product of zero.
- R7: The top column never produces bits above bit 15. With the largest operands, 0xFF × 0xFF, the result is 0xFE01.
- R8: Multiplying by 1 returns the other operand unchanged, with zeros in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Multiplicand, unsigned |
| opB | input | 8 | Multiplier, unsigned |
| prodOut | output | 16 | Unsigned product opA × opB |

## Verification
Two things can happen in the same evaluation: the column for bits 7:4 passes up a carry of two, and the column for bits 11:8 must absorb that carry together with its own three full nibbles. The bench provokes this on purpose, with operand pairs such as 0x7F × 0x7F and 0xFF × 0xFF, where both middle columns hold large values at once. It judges the result by comparing the whole 16-bit product with an arithmetic multiply, and by checking that the low nibble matches the low×low product alone. The exhaustive sweep then covers every other case where a column's carry and its own operands meet.

// File: rtl/decompMul8_pkg.sv
package decompMul8_pkg;

  // Default half-operand width used throughout the block.
  localparam int HALF_W = 4;

  // Unary (thermometer) form of a column carry of 0..2.
  typedef struct packed {
    logic lo;  // set when the carry is at least 1
    logic hi;  // set when the carry is 2
  } colCarry_t;

  // Convert the two bits that overflow a column into thermometer form.
  function automatic colCarry_t toThermo(input logic [1:0] ovf);
    colCarry_t c;
    c.lo = ovf[1] | ovf[0];
    c.hi = ovf[1];
    return c;
  endfunction

endpackage

// File: rtl/fullAdd.sv
module fullAdd (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic halfSum;
  assign halfSum = x ^ y;
  assign s       = halfSum ^ ci;
  assign co      = (x & y) | (ci & halfSum);
endmodule

// File: rtl/arrayMul4.sv
module arrayMul4 #(
  parameter int W = 4
) (
  input  logic [W-1:0]   mulA,
  input  logic [W-1:0]   mulB,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0] cellSum [W];
  logic [W:0]   cellCarry [W];
  logic [W-1:0] sumIn [W];
  logic [W-1:0] ppBit [W];

  for (genvar j = 0; j < W; j++) begin : gRow
    assign cellCarry[j][0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : gCol
      assign ppBit[j][i] = mulA[i] & mulB[j];
      if (j == 0) begin : gFirst
        assign sumIn[j][i] = 1'b0;
      end else if (i < W - 1) begin : gShift
        assign sumIn[j][i] = cellSum[j-1][i+1];
      end else begin : gTop
        assign sumIn[j][i] = cellCarry[j-1][W];
      end
      fullAdd uCell (
        .x (ppBit[j][i]),
        .y (sumIn[j][i]),
        .ci(cellCarry[j][i]),
        .s (cellSum[j][i]),
        .co(cellCarry[j][i+1])
      );
    end
    assign prod[j] = cellSum[j][0];
  end

  for (genvar i = 1; i < W; i++) begin : gUpper
    assign prod[W-1+i] = cellSum[W-1][i];
  end
  assign prod[PW-1] = cellCarry[W-1][W];

  always_comb begin
    AST_SUBPROD_EXACT: assert (prod == PW'(mulA) * PW'(mulB)); // R3
  end
endmodule

// File: rtl/nibbleSum3.sv
module nibbleSum3 #(
  parameter int W = 4
) (
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inZ,
  input  logic         cinLo,
  input  logic         cinHi,
  output logic [W+1:0] colRes
);
  localparam int RW = W + 2;

  logic [W-1:0] rowS;
  logic [W-1:0] rowC;
  logic [W:0]   opU;
  logic [W:0]   opV;
  logic [W+1:0] chain;

  // Rank of full adders: three bits per position reduced to sum and carry.
  for (genvar i = 0; i < W; i++) begin : gReduce
    fullAdd uRed (
      .x (inX[i]),
      .y (inY[i]),
      .ci(inZ[i]),
      .s (rowS[i]),
      .co(rowC[i])
    );
  end

  // Carry vector moves up one place; the free slot takes one carry-in wire,
  // the adder's own carry-in takes the other.
  assign opU = {1'b0, rowS};
  assign opV = {rowC, cinLo};
  assign chain[0] = cinHi;

  for (genvar k = 0; k <= W; k++) begin : gRipple
    fullAdd uRip (
      .x (opU[k]),
      .y (opV[k]),
      .ci(chain[k]),
      .s (colRes[k]),
      .co(chain[k+1])
    );
  end
  assign colRes[W+1] = chain[W+1];

  always_comb begin
    AST_COL_EXACT: assert (colRes == RW'(inX) + RW'(inY) + RW'(inZ)
                           + RW'(cinLo) + RW'(cinHi)); // R5
    AST_CIN_THERMO: assert (!(cinHi && !cinLo)); // R4
  end
endmodule

// File: rtl/decompMul8.sv
module decompMul8
  import decompMul8_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic [2*HW-1:0] opA,
  input  logic [2*HW-1:0] opB,
  output logic [4*HW-1:0] prodOut
);
  localparam int OW = 2 * HW;
  localparam int PW = 4 * HW;
  localparam int NSUB = 4;

  logic [HW-1:0]   aHalf [2];
  logic [HW-1:0]   bHalf [2];
  logic [OW-1:0]   subProd [NSUB];
  logic [HW+1:0]   colMid1;
  logic [HW+1:0]   colMid2;
  logic [HW+1:0]   colTop;
  colCarry_t       carry1;
  colCarry_t       carry2;

  assign aHalf[0] = opA[HW-1:0];
  assign aHalf[1] = opA[OW-1:HW];
  assign bHalf[0] = opB[HW-1:0];
  assign bHalf[1] = opB[OW-1:HW];

  // subProd[k]: A half selected by k[0], B half selected by k[1].
  for (genvar k = 0; k < NSUB; k++) begin : gSub
    arrayMul4 #(.W(HW)) uSub (
      .mulA(aHalf[k % 2]),
      .mulB(bHalf[k / 2]),
      .prod(subProd[k])
    );
  end

  nibbleSum3 #(.W(HW)) uColMid1 (
    .inX  (subProd[0][OW-1:HW]),
    .inY  (subProd[1][HW-1:0]),
    .inZ  (subProd[2][HW-1:0]),
    .cinLo(1'b0),
    .cinHi(1'b0),
    .colRes(colMid1)
  );
  assign carry1 = toThermo(colMid1[HW+1:HW]);

  nibbleSum3 #(.W(HW)) uColMid2 (
    .inX  (subProd[1][OW-1:HW]),
    .inY  (subProd[2][OW-1:HW]),
    .inZ  (subProd[3][HW-1:0]),
    .cinLo(carry1.lo),
    .cinHi(carry1.hi),
    .colRes(colMid2)
  );
  assign carry2 = toThermo(colMid2[HW+1:HW]);

  nibbleSum3 #(.W(HW)) uColTop (
    .inX  (subProd[3][OW-1:HW]),
    .inY  ({HW{1'b0}}),
    .inZ  ({HW{1'b0}}),
    .cinLo(carry2.lo),
    .cinHi(carry2.hi),
    .colRes(colTop)
  );

  assign prodOut = {colTop[HW-1:0], colMid2[HW-1:0], colMid1[HW-1:0],
                    subProd[0][HW-1:0]};

  always_comb begin
    AST_PRODUCT_EXACT: assert (prodOut == PW'(opA) * PW'(opB)); // R1
    AST_CARRY_BOUND1: assert (colMid1[HW+1:HW] != 2'b11); // R4
    AST_CARRY_BOUND2: assert (colMid2[HW+1:HW] != 2'b11); // R4
    AST_TOP_FITS: assert (colTop[HW+1:HW] == 2'b00); // R7
    AST_ZERO_OPERAND: assert (!((opA == '0) || (opB == '0)) || (prodOut == '0)); // R6
  end
endmodule

// File: tb/sim_decompMul8.sv
module sim_decompMul8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [15:0] prodOut;
  int          nVec = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  decompMul8 u0 (
    .opA    (opA),
    .opB    (opB),
    .prodOut(prodOut)
  );

  task automatic check(input string req, input int got, input int exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s a=%0h b=%0h actual=%0h expected=%0h", req, opA, opB, got, exp);
    end
  endtask

  // Drive on a rising edge, observe at the following falling edge.
  task automatic drive(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    opA = a;
    opB = b;
    @(negedge clk);
  endtask

  task automatic tResetState;
    drive(8'h00, 8'h00);
    check("R6 reset zero", int'(prodOut), 0);
  endtask

  task automatic tZeroOperand;
    drive(8'h00, 8'hFF); check("R6 zero A", int'(prodOut), 0);
    drive(8'hA5, 8'h00); check("R6 zero B", int'(prodOut), 0);
  endtask

  task automatic tIdentity;
    drive(8'h01, 8'hC3); check("R8 one times B", int'(prodOut), 'hC3);
    drive(8'h5A, 8'h01); check("R8 A times one", int'(prodOut), 'h5A);
    drive(8'hFF, 8'h01); check("R8 max times one", int'(prodOut), 'hFF);
  endtask

  task automatic tCarryTwo;
    drive(8'h7F, 8'h7F);
    check("R4 double column carry", int'(prodOut), 'h3F01);
    check("R2 low nibble", int'(prodOut[3:0]), (15 * 15) % 16);
  endtask

  task automatic tMaxOperands;
    drive(8'hFF, 8'hFF);
    check("R7 largest product", int'(prodOut), 'hFE01);
    drive(8'hF0, 8'hF0);
    check("R7 high halves only", int'(prodOut), 'hE100);
  endtask

  task automatic tSubProducts;
    // Isolate each cross product by zeroing the other halves.
    drive(8'h0D, 8'h0B); check("R3 low x low", int'(prodOut), 13 * 11);
    drive(8'hD0, 8'h0B); check("R3 high x low", int'(prodOut), 13 * 11 * 16);
    drive(8'h0D, 8'hB0); check("R3 low x high", int'(prodOut), 13 * 11 * 16);
    drive(8'hD0, 8'hB0); check("R3 high x high", int'(prodOut), 13 * 11 * 256);
  endtask

  task automatic tColumnSums;
    drive(8'hFF, 8'h11); check("R5 column sums", int'(prodOut), 255 * 17);
    drive(8'h9E, 8'hE7); check("R5 mixed column", int'(prodOut), 'h9E * 'hE7);
  endtask

  task automatic tExhaustive;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive(8'(a), 8'(b));
        check("R1 exhaustive", int'(prodOut), a * b);
        if (prodOut[3:0] != 4'(((a % 16) * (b % 16)) % 16)) begin
          check("R2 low nibble", int'(prodOut[3:0]), ((a % 16) * (b % 16)) % 16);
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    tResetState();
    tZeroOperand();
    tIdentity();
    tCarryTwo();
    tMaxOperands();
    tSubProducts();
    tColumnSums();
    tExhaustive();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES * 2) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule